// File: doc/BRIEF.md
# Interrupt Arbitration and Masking Controller

This block decides which interrupt a small 8-bit processor core takes next. Maskable sources deliver one-cycle request pulses. The block latches each pulse into a pending bit until that source is granted. A software trap strobe is latched in the same way. At an instruction boundary, which the core signals with a strobe, the block grants either the trap or the highest-priority pending maskable source. It returns the granted index to the core one cycle later, together with a one-cycle take pulse.

A single global mask bit gates the maskable sources. The mask bit comes up set out of reset. Hardware sets it on every grant, so a running handler is not preempted. The core's return-from-interrupt strobe clears it. The trap ignores the mask and outranks every maskable source.

While the core sits in a low-power state, the block raises a wake-up output. In the light sleep state (WAIT), any pending source raises it. In the deep sleep state (HALT), only sources marked in a per-source parameter raise it.

Top module: `irq_arb_top`

## Requirements
- R1: While reset is asserted, and after it is released, `mask_o` is 1, `take_o` is 0, `wake_o` is 0, and no request remains pending. A reset during operation discards every latched request.
- R2: A maskable source is granted only on a clock edge where `boundary_i` is 1, the mask is clear, and no trap is latched. `take_o` is 1 for exactly the one cycle after that edge.
- R3: Every grant sets `mask_o` on the same edge that raises `take_o`. A `iret_i` pulse clears `mask_o` on the next edge unless a grant occurs on that same edge. If both happen on one edge, the grant wins and the mask stays set.
- R4: A latched trap is granted at the next boundary whatever the value of `mask_o`. It is reported as vector index NSRC (8 with the defaults).
- R5: When several maskable sources are pending, the lowest index is granted first. A latched trap outranks all maskable sources at the same boundary.
- R6: A request pulse on `req_i[k]` sets pending bit k, which holds across masked periods until source k is granted. A new pulse on the same edge as the grant keeps the bit pending.
- R7: With `wait_i` high, `wake_o` is 1 whenever any maskable request is pending, regardless of the mask.
- R8: With only `halt_i` high, `wake_o` is 1 only when a pending request belongs to a source whose bit is set in `HALT_WAKE_MASK` (default: sources 0 to 3).
- R9: While `take_o` is 1, `vec_o` holds the index of the granted source (0 to NSRC-1 for maskable sources, NSRC for the trap).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NSRC | One-cycle request pulses from maskable sources |
| trap_i | input | 1 | Software trap strobe |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| iret_i | input | 1 | Return-from-interrupt strobe from the core |
| wait_i | input | 1 | Core is in the light sleep state |
| halt_i | input | 1 | Core is in the deep sleep state |
| take_o | output | 1 | One-cycle pulse: the core must enter the handler |
| vec_o | output | $clog2(NSRC+1) | Index of the granted source |
| mask_o | output | 1 | Current global mask bit |
| wake_o | output | 1 | Wake-up request for the low-power states |

## Verification
The table drives two maskable sources pending at the same time, which shows that the lowest index is granted first. It also raises a trap while a maskable source is pending, which shows that the trap outranks it. Boundaries presented while the mask is set, and a return strobe on the same edge as a boundary, separate the mask gating from the boundary gating. HALT wake is tried first with only an unmarked source pending and then with a marked one added, while WAIT wake is tried with an unmarked source pending. Directed tests cover a request re-arriving on its own grant edge, a pending request with no boundary, and a reset during operation that drops latched requests.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Power state seen by the wake-up logic; deep sleep dominates.
  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_WAIT = 2'd1,
    PWR_HALT = 2'd2
  } pwr_mode_e;

  function automatic pwr_mode_e decode_pwr(input logic wait_m, input logic halt_m);
    if (halt_m)      return PWR_HALT;
    else if (wait_m) return PWR_WAIT;
    else             return PWR_RUN;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar k = 0; k < N; k++) begin : g_bit
    // A new request wins over a clear on the same edge (R6).
    always_comb begin
      pend_d[k] = pend_q[k];
      if (clr_i[k]) pend_d[k] = 1'b0;
      if (set_i[k]) pend_d[k] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[k] <= 1'b0;
      else         pend_q[k] <= pend_d[k];
    end
  end

  assign pend_o = pend_q;

  // R6: every request pulse is visible as pending on the next cycle.
  assert_req_latched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R6: a bit only drops when cleared by a grant without a fresh request.
  assert_drop_needs_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_q & ~clr_i)) |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  // Walk from the highest index down so the lowest pending index is kept (R5).
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (pend_i[k]) idx_o = IW'(k);
    end
  end

  assign any_o = |pend_i;

  // One-hot of the winner: isolate the lowest set bit.
  assign onehot_o = pend_i & (~pend_i + N'(1));
endmodule

// File: rtl/irq_grant_ctl.sv
module irq_grant_ctl #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1,
  parameter int VW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          boundary_i,
  input  logic          trap_i,
  input  logic          iret_i,
  input  logic          any_i,
  input  logic [IW-1:0] idx_i,
  input  logic [N-1:0]  onehot_i,
  output logic          take_o,
  output logic [VW-1:0] vec_o,
  output logic          mask_o,
  output logic [N-1:0]  clr_o
);
  localparam logic [VW-1:0] TRAP_VEC = VW'(N);

  logic          trap_q, trap_d;
  logic          mask_q, mask_d;
  logic          take_q, take_d;
  logic [VW-1:0] vec_q,  vec_d;
  logic          vec_en;
  logic          grant_trap, grant_mskb, grant;

  // Grant decision at an instruction boundary.
  always_comb begin
    grant_trap = boundary_i & trap_q;
    grant_mskb = boundary_i & ~trap_q & ~mask_q & any_i;
    grant      = grant_trap | grant_mskb;
  end

  // Next-state logic.
  always_comb begin
    trap_d = trap_q;
    if (grant_trap) trap_d = 1'b0;
    if (trap_i)     trap_d = 1'b1;

    mask_d = mask_q;
    if (iret_i) mask_d = 1'b0;
    if (grant)  mask_d = 1'b1;

    take_d = grant;
    vec_en = grant;
    vec_d  = grant_trap ? TRAP_VEC : VW'(idx_i);

    clr_o  = grant_mskb ? onehot_i : '0;
  end

  // Registers.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q <= 1'b0;
      mask_q <= 1'b1;
      take_q <= 1'b0;
    end else begin
      trap_q <= trap_d;
      mask_q <= mask_d;
      take_q <= take_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
  assign mask_o = mask_q;

  // R2: a maskable grant needs a boundary and a clear mask on the previous edge.
  assert_maskable_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_q && vec_q != TRAP_VEC) |-> $past(boundary_i && !mask_q));

  // R3: a taken interrupt always leaves the mask set.
  assert_take_masks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_q |-> mask_q);

  // R3: a return without a concurrent grant clears the mask.
  assert_iret_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iret_i && !grant) |=> !mask_q);

  // R4: a latched trap is taken at the boundary whatever the mask.
  assert_trap_unmasked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && trap_q) |=> (take_q && vec_q == TRAP_VEC));

  // R9: a maskable index never exceeds the source range.
  assert_vec_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_q |-> (vec_q <= TRAP_VEC));
endmodule

// File: rtl/irq_wake_det.sv
module irq_wake_det #(
  parameter int           N         = 8,
  parameter logic [N-1:0] HALT_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wait_i,
  input  logic         halt_i,
  input  logic [N-1:0] pend_i,
  output logic         wake_o
);
  import irq_arb_pkg::*;

  pwr_mode_e mode;

  always_comb begin
    mode = decode_pwr(wait_i, halt_i);
    unique case (mode)
      PWR_WAIT: wake_o = |pend_i;
      PWR_HALT: wake_o = |(pend_i & HALT_MASK);
      default:  wake_o = 1'b0;
    endcase
  end

  // R8: in deep sleep, unmarked sources alone never wake the core.
  assert_halt_marked_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && ((pend_i & HALT_MASK) == '0)) |-> !wake_o);

  // R7: in light sleep, any pending source wakes the core.
  assert_wait_any_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && !halt_i && (|pend_i)) |-> wake_o);
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top #(
  parameter int               NSRC           = 8,
  parameter logic [NSRC-1:0]  HALT_WAKE_MASK = NSRC'(8'h0F),
  localparam int              IW             = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int              VW             = $clog2(NSRC + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  input  logic            trap_i,
  input  logic            boundary_i,
  input  logic            iret_i,
  input  logic            wait_i,
  input  logic            halt_i,
  output logic            take_o,
  output logic [VW-1:0]   vec_o,
  output logic            mask_o,
  output logic            wake_o
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] onehot;
  logic            any;
  logic [IW-1:0]   idx;

  irq_pend_bank #(.N(NSRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .set_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_prio_pick #(.N(NSRC), .IW(IW)) u_pick (
    .pend_i   (pend),
    .any_o    (any),
    .idx_o    (idx),
    .onehot_o (onehot)
  );

  irq_grant_ctl #(.N(NSRC), .IW(IW), .VW(VW)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .boundary_i (boundary_i),
    .trap_i     (trap_i),
    .iret_i     (iret_i),
    .any_i      (any),
    .idx_i      (idx),
    .onehot_i   (onehot),
    .take_o     (take_o),
    .vec_o      (vec_o),
    .mask_o     (mask_o),
    .clr_o      (clr)
  );

  irq_wake_det #(.N(NSRC), .HALT_MASK(HALT_WAKE_MASK)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .wait_i (wait_i),
    .halt_i (halt_i),
    .pend_i (pend),
    .wake_o (wake_o)
  );

  // R5: a maskable grant clears exactly the lowest pending bit.
  assert_lowest_first_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(clr) && ((clr == '0) || ((pend & (clr - NSRC'(1))) == '0)));
endmodule

// File: tb/tb_irq_arb_top.sv
module tb_irq_arb_top;
  localparam int NSRC = 8;
  localparam int VW   = $clog2(NSRC + 1);
  localparam int NV   = 18;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] req;
  logic            trap, bnd, iret, wt, ht;
  logic            take, mask, wake;
  logic [VW-1:0]   vec;

  int applied = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  irq_arb_top #(.NSRC(NSRC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .trap_i(trap),
    .boundary_i(bnd), .iret_i(iret), .wait_i(wt), .halt_i(ht),
    .take_o(take), .vec_o(vec), .mask_o(mask), .wake_o(wake)
  );

  // Row: req[8] | trap bnd iret wait halt | exp take | exp vec[4] | exp mask | exp wake
  localparam logic [19:0] TBL [NV] = '{
    {8'h00, 5'b00100, 1'b0, 4'd0, 1'b0, 1'b0}, // R3 return clears mask
    {8'h24, 5'b00000, 1'b0, 4'd0, 1'b0, 1'b0}, // R2 pending, no boundary
    {8'h00, 5'b01000, 1'b1, 4'd2, 1'b1, 1'b0}, // R5 lowest of {5,2}
    {8'h00, 5'b01010, 1'b0, 4'd0, 1'b1, 1'b1}, // R2 masked; R7 wait wake
    {8'h00, 5'b00001, 1'b0, 4'd0, 1'b1, 1'b0}, // R8 src 5 unmarked
    {8'h00, 5'b01100, 1'b0, 4'd0, 1'b0, 1'b0}, // R3 iret with boundary
    {8'h00, 5'b01000, 1'b1, 4'd5, 1'b1, 1'b0}, // R6 held source taken
    {8'h00, 5'b10000, 1'b0, 4'd0, 1'b1, 1'b0}, // R4 trap latched
    {8'h00, 5'b01000, 1'b1, 4'd8, 1'b1, 1'b0}, // R4 trap under mask
    {8'h80, 5'b00001, 1'b0, 4'd0, 1'b1, 1'b0}, // R8 src 7 unmarked
    {8'h08, 5'b00001, 1'b0, 4'd0, 1'b1, 1'b1}, // R8 src 3 marked
    {8'h00, 5'b10100, 1'b0, 4'd0, 1'b0, 1'b0}, // R3 clear + trap latched
    {8'h00, 5'b01000, 1'b1, 4'd8, 1'b1, 1'b0}, // R5 trap beats {7,3}
    {8'h00, 5'b00100, 1'b0, 4'd0, 1'b0, 1'b0},
    {8'h00, 5'b01000, 1'b1, 4'd3, 1'b1, 1'b0}, // R9 index 3
    {8'h00, 5'b00100, 1'b0, 4'd0, 1'b0, 1'b0},
    {8'h00, 5'b01000, 1'b1, 4'd7, 1'b1, 1'b0}, // R9 index 7
    {8'h00, 5'b01010, 1'b0, 4'd0, 1'b1, 1'b0}  // R7 nothing pending
  };

  task automatic check(input string tag, input int act, input int exp);
    applied++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [7:0] r, input logic [4:0] c);
    req  = r;
    trap = c[4]; bnd = c[3]; iret = c[2]; wt = c[1]; ht = c[0];
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(8'h00, 5'b00000);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle();
    wt = 1'b1;
    repeat (3) step();
    check("R1 take in reset", int'(take), 0);
    check("R1 mask in reset", int'(mask), 1);
    check("R1 wake in reset", int'(wake), 0);
    rst_n = 1'b1;
    repeat (3) step();
    wt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    #2;
    do_reset();
    check("R1 take after reset", int'(take), 0);
    check("R1 mask after reset", int'(mask), 1);
    check("R1 wake after reset", int'(wake), 0);

    // Table walk.
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i][19:12], TBL[i][11:7]);
      step();
      check("R2 take", int'(take), int'(TBL[i][6]));
      if (TBL[i][6]) check("R9 vec", int'(vec), int'(TBL[i][5:2]));
      check("R3 mask", int'(mask), int'(TBL[i][1]));
      if (TBL[i][7]) check("R8 wake", int'(wake), int'(TBL[i][0]));
      else           check("R7 wake", int'(wake), int'(TBL[i][0]));
    end

    // R6: a request re-arriving on its own grant edge stays pending.
    drive(8'h00, 5'b00100); step();
    drive(8'h02, 5'b00000); step();
    drive(8'h02, 5'b01000); step();
    check("R6 first grant", int'(take), 1);
    check("R6 first vec", int'(vec), 1);
    drive(8'h00, 5'b00100); step();
    drive(8'h00, 5'b01000); step();
    check("R6 re-armed grant", int'(take), 1);
    check("R6 re-armed vec", int'(vec), 1);

    // R2: pending and unmasked but no boundary gives nothing; take lasts one cycle.
    drive(8'h00, 5'b00100); step();
    drive(8'h01, 5'b00000); step();
    idle(); step();
    check("R2 no boundary", int'(take), 0);
    drive(8'h00, 5'b01000); step();
    check("R2 boundary take", int'(take), 1);
    check("R9 vec zero", int'(vec), 0);
    idle(); step();
    check("R2 single pulse", int'(take), 0);

    // R1: reset during operation discards latched requests.
    drive(8'h00, 5'b00100); step();
    drive(8'h10, 5'b00000); step();
    do_reset();
    drive(8'h00, 5'b00100); step();
    drive(8'h00, 5'b01010); step();
    check("R1 pending dropped take", int'(take), 0);
    check("R1 pending dropped wake", int'(wake), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule